// File: doc/BRIEF.md
# Multiplexed LCD Common/Segment Scanner

This block time-multiplexes a 40-segment, 8-common liquid-crystal panel from an 80-nibble display store. A slow tick (nominally 32.768 kHz) advances a frame counter that walks the commons in equal phases. At the start of every phase the block captures one bit per segment from the store. For every pin it then produces a 3-bit index that tells the analog level generator which of five voltages (V0 to V4) to connect. The drive polarity flips at every frame boundary, so the panel sees no net DC.

Software sets the configuration through a small 4-bit register port: the duty (all eight commons, or only commons 0 to 3), the bias (1/3 or 1/4) and a 4-bit frame-rate code. The same port can hand segments 16 to 39, in groups of four, and the upper four commons to general-purpose use. A handed-over pin shows its GPIO value in place of a level index, and display data no longer affects it.

Top module: `lcd_scan`

## Requirements
- R1: After reset: duty is eight commons, bias is 1/3, rate code is 7, no pin is handed over, the polarity is positive and common 0 is the selected common.
- R2: With rate code k (values above 7 act as 7), a frame lasts 2^(16-k) asserted ticks. The frame is split into equal phases, one per scanned common, in ascending common order. Clock cycles without tick do not advance the scan.
- R3: The polarity inverts exactly when the frame counter wraps to zero and at no other time. Polarity 0 is positive.
- R4: With a = 3 for 1/3 bias and a = 4 for 1/4 bias, positive polarity drives the selected common at a, the other commons at 1, lit segments at 0 and dark segments at 2. Negative polarity drives the selected common at 0, the other commons at a-1, lit segments at a and dark segments at a-2.
- R5: Segment s during the phase of common c is lit when bit (c mod 4) of nibble 2s + (c div 4) is 1. Store writes to offsets 80 and above are ignored.
- R6: Segment data is captured on the tick that starts a phase. A store write made during a phase first shows in the next phase.
- R7: In four-common duty, a phase lasts twice as long, only commons 0 to 3 are scanned, and commons 4 to 7 that are not handed over sit at the unselected level.
- R8: Segment group g (segments 16+4g to 19+4g) is handed over when its control bit is 1. Each of its pins then raises its seg_rel bit and outputs level {2'b00, seg_gpio[s-16]}, whatever the display data.
- R9: Commons 4 to 7 are handed over only when the common-share bit is 1 and the duty is four-common. They then raise com_rel and output {2'b00, com_gpio[c-4]}. In eight-common duty the share bit has no effect.
- R10: Register map (write on cfg_we): address 0 has bit 0 = four-common duty and bit 1 = 1/4 bias. Address 1 holds the rate code. Address 2 bits 0 to 3 release groups 0 to 3. Address 3 bits 0 and 1 release groups 4 and 5, and bit 2 is the common-share bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Scan time base enable, one pulse per 32.768 kHz period |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | 4 | Configuration write data |
| ram_we | input | 1 | Display store write strobe |
| ram_addr | input | 7 | Display store nibble offset |
| ram_wdata | input | 4 | Display store write data |
| seg_gpio | input | 24 | GPIO values for segments 16 to 39 (bit i is segment 16+i) |
| com_gpio | input | 4 | GPIO values for commons 4 to 7 |
| seg_lvl | output | 120 | Level index per segment, 3 bits each, segment s at [3s+2:3s] |
| com_lvl | output | 24 | Level index per common, 3 bits each |
| seg_rel | output | 40 | Segment pin handed over to GPIO |
| com_rel | output | 8 | Common pin handed over to GPIO |

## Verification
The counter, the polarity and the captured segment bits change on the same edge as the tick that causes them. Configuration and GPIO changes reach the level outputs through logic alone, right after the writing edge. Each scenario resets the block, configures it with tick low so the scan stays frozen, and then asserts tick for an exact number of cycles, so the bench knows the counter value. It samples on the falling edge that follows. Store writes are checked only in phases entered after the write, because capture happens only at phase starts.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

   typedef logic [2:0] lvl_t;

   // top level of the drive ladder for the chosen bias
   function automatic lvl_t ladder_top(input logic bias4);
      return bias4 ? lvl_t'(4) : lvl_t'(3);
   endfunction

   function automatic lvl_t com_level(input logic sel, input logic neg, input logic bias4);
      lvl_t a;
      a = ladder_top(bias4);
      if (!neg) return sel ? a : lvl_t'(1);
      else      return sel ? lvl_t'(0) : lvl_t'(a - lvl_t'(1));
   endfunction

   function automatic lvl_t seg_level(input logic lit, input logic neg, input logic bias4);
      lvl_t a;
      a = ladder_top(bias4);
      if (!neg) return lit ? lvl_t'(0) : lvl_t'(2);
      else      return lit ? a : lvl_t'(a - lvl_t'(2));
   endfunction

endpackage

// File: rtl/lcd_scan_cfg.sv
module lcd_scan_cfg #(
   parameter int NGRP       = 6,
   parameter int RATE_W     = 4,
   parameter int RATE_RESET = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [1:0]        addr,
   input  logic [3:0]        wdata,
   output logic              duty4,
   output logic              bias4,
   output logic [RATE_W-1:0] rate,
   output logic [NGRP-1:0]   grp_rel,
   output logic              com_share
);
   initial begin : elab_chk
      assert (NGRP >= 1 && NGRP <= 6) else $error("NGRP must be 1..6");
      assert (RATE_W == 4) else $error("RATE_W must be 4");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         duty4     <= 1'b0;
         bias4     <= 1'b0;
         rate      <= RATE_W'(RATE_RESET);
         grp_rel   <= '0;
         com_share <= 1'b0;
      end else if (we) begin
         case (addr)
            2'd0: begin
               duty4 <= wdata[0];
               bias4 <= wdata[1];
            end
            2'd1: rate <= wdata;
            2'd2: begin
               for (int g = 0; g < NGRP; g++)
                  if (g < 4) grp_rel[g] <= wdata[2'(g)];
            end
            default: begin
               for (int g = 0; g < NGRP; g++)
                  if (g >= 4) grp_rel[g] <= wdata[2'(g - 4)];
               com_share <= wdata[2];
            end
         endcase
      end
   end
endmodule

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer #(
   parameter int BASE_LOG = 16,
   parameter int MAX_RATE = 7,
   parameter int RATE_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              duty4,
   input  logic [RATE_W-1:0] rate,
   output logic [2:0]        com_idx,
   output logic              neg,
   output logic              latch_en,
   output logic [2:0]        latch_com
);
   localparam int CNT_W = BASE_LOG;
   localparam logic [4:0] BASE_L5 = 5'(BASE_LOG);

   initial begin : elab_chk
      assert (BASE_LOG - MAX_RATE >= 3 && BASE_LOG <= 24) else $error("bad frame range");
   end

   logic [CNT_W-1:0] tcnt_q, tcnt_nxt, pmask, com_full, com_nfull;
   logic [CNT_W:0]   last;
   logic [4:0]       kk, flen_log, phase_log;
   logic             wrap;

   always_comb begin
      kk        = (rate > RATE_W'(MAX_RATE)) ? 5'(MAX_RATE) : 5'(rate);
      flen_log  = BASE_L5 - kk;
      phase_log = flen_log - (duty4 ? 5'd2 : 5'd3);
      last      = ((CNT_W+1)'(1) << flen_log) - (CNT_W+1)'(1);
      wrap      = ({1'b0, tcnt_q} >= last);
      tcnt_nxt  = wrap ? '0 : tcnt_q + CNT_W'(1);
      pmask     = (CNT_W'(1) << phase_log) - CNT_W'(1);
      com_full  = tcnt_q >> phase_log;
      com_nfull = tcnt_nxt >> phase_log;
      com_idx   = duty4 ? {1'b0, com_full[1:0]} : com_full[2:0];
      latch_com = duty4 ? {1'b0, com_nfull[1:0]} : com_nfull[2:0];
      latch_en  = tick && ((tcnt_nxt & pmask) == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tcnt_q <= '0;
         neg    <= 1'b0;
      end else if (tick) begin
         tcnt_q <= tcnt_nxt;
         if (wrap) neg <= ~neg;
      end
   end

   // R3: polarity may only change as the frame counter restarts
   assert_pol_at_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(neg) |-> (tcnt_q == '0));
endmodule

// File: rtl/lcd_scan_ram.sv
module lcd_scan_ram #(
   parameter int NUM_SEG = 40,
   parameter int DATA_W  = 4,
   parameter int AW      = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [AW-1:0]      addr,
   input  logic [DATA_W-1:0]  wdata,
   input  logic               latch_en,
   input  logic [2:0]         latch_com,
   output logic [NUM_SEG-1:0] seg_bits
);
   localparam int DEPTH = 2 * NUM_SEG;

   initial begin : elab_chk
      assert (DATA_W == 4) else $error("nibble store needs DATA_W 4");
      assert ((1 << AW) >= DEPTH) else $error("AW too small");
   end

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we && ({1'b0, addr} < (AW+1)'(DEPTH))) begin
         mem[addr] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seg_bits <= '0;
      end else if (latch_en) begin
         for (int s = 0; s < NUM_SEG; s++)
            seg_bits[s] <= mem[AW'(2 * s) | AW'(latch_com[2])][latch_com[1:0]];
      end
   end
endmodule

// File: rtl/lcd_scan_drive.sv
module lcd_scan_drive
   import lcd_scan_pkg::*;
#(
   parameter int NUM_SEG    = 40,
   parameter int NUM_COM    = 8,
   parameter int SHARE_BASE = 16,
   parameter int GRP_W      = 4,
   parameter int NGRP       = 6
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [2:0]                    com_idx,
   input  logic                          neg,
   input  logic                          duty4,
   input  logic                          bias4,
   input  logic [NUM_SEG-1:0]            seg_bits,
   input  logic [NGRP-1:0]               grp_rel,
   input  logic                          com_share,
   input  logic [NUM_SEG-SHARE_BASE-1:0] seg_gpio,
   input  logic [NUM_COM/2-1:0]          com_gpio,
   output logic [NUM_SEG*3-1:0]          seg_lvl,
   output logic [NUM_COM*3-1:0]          com_lvl,
   output logic [NUM_SEG-1:0]            seg_rel,
   output logic [NUM_COM-1:0]            com_rel
);
   localparam int HALF = NUM_COM / 2;

   initial begin : elab_chk
      assert (NUM_COM == 8) else $error("scan supports 8 commons");
      assert (NGRP * GRP_W == NUM_SEG - SHARE_BASE) else $error("group layout mismatch");
   end

   logic [NUM_COM-1:0] at_sel;

   for (genvar c = 0; c < NUM_COM; c++) begin : g_com
      if (c < HALF) begin : g_fixed
         assign com_rel[c] = 1'b0;
         assign com_lvl[3*c +: 3] = com_level(com_idx == 3'(c), neg, bias4);
      end else begin : g_shared
         assign com_rel[c] = duty4 & com_share;
         assign com_lvl[3*c +: 3] = com_rel[c] ? lvl_t'(com_gpio[c-HALF])
                                  : com_level(!duty4 && (com_idx == 3'(c)), neg, bias4);
      end
      assign at_sel[c] = !com_rel[c] && (com_lvl[3*c +: 3] == (neg ? lvl_t'(0) : ladder_top(bias4)));

      // R4: no common index beyond the top of the ladder
      assert_com_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
         com_lvl[3*c +: 3] <= lvl_t'(4));
   end

   for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
      if (s < SHARE_BASE) begin : g_fixed
         assign seg_rel[s] = 1'b0;
         assign seg_lvl[3*s +: 3] = seg_level(seg_bits[s], neg, bias4);
      end else begin : g_shared
         assign seg_rel[s] = grp_rel[(s-SHARE_BASE)/GRP_W];
         assign seg_lvl[3*s +: 3] = seg_rel[s] ? lvl_t'(seg_gpio[s-SHARE_BASE])
                                  : seg_level(seg_bits[s], neg, bias4);
      end

      // R8: a handed-over pin carries only a 0/1 GPIO value
      assert_rel_binary_R8: assert property (@(posedge clk) disable iff (!rst_n)
         seg_rel[s] |-> (seg_lvl[3*s+1 +: 2] == 2'b00));
   end

   // R7: exactly one scanned common sits at the selected level
   assert_one_select_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(at_sel) == 1);

   // R9: upper commons stay in the scan while all eight are driven
   assert_com_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !duty4 |-> (com_rel == '0));
endmodule

// File: rtl/lcd_scan.sv
module lcd_scan #(
   parameter int NUM_SEG    = 40,
   parameter int NUM_COM    = 8,
   parameter int SHARE_BASE = 16,
   parameter int GRP_W      = 4,
   parameter int BASE_LOG   = 16,
   parameter int MAX_RATE   = 7,
   parameter int RATE_RESET = 7,
   parameter int AW         = 7
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          tick,
   input  logic                          cfg_we,
   input  logic [1:0]                    cfg_addr,
   input  logic [3:0]                    cfg_wdata,
   input  logic                          ram_we,
   input  logic [AW-1:0]                 ram_addr,
   input  logic [3:0]                    ram_wdata,
   input  logic [NUM_SEG-SHARE_BASE-1:0] seg_gpio,
   input  logic [NUM_COM/2-1:0]          com_gpio,
   output logic [NUM_SEG*3-1:0]          seg_lvl,
   output logic [NUM_COM*3-1:0]          com_lvl,
   output logic [NUM_SEG-1:0]            seg_rel,
   output logic [NUM_COM-1:0]            com_rel
);
   localparam int NGRP   = (NUM_SEG - SHARE_BASE) / GRP_W;
   localparam int RATE_W = 4;

   logic              duty4, bias4, com_share, neg, latch_en;
   logic [RATE_W-1:0] rate;
   logic [NGRP-1:0]   grp_rel;
   logic [2:0]        com_idx, latch_com;
   logic [NUM_SEG-1:0] seg_bits;

   lcd_scan_cfg #(.NGRP(NGRP), .RATE_W(RATE_W), .RATE_RESET(RATE_RESET)) u_cfg (
      .clk, .rst_n, .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
      .duty4, .bias4, .rate, .grp_rel, .com_share);

   lcd_scan_timer #(.BASE_LOG(BASE_LOG), .MAX_RATE(MAX_RATE), .RATE_W(RATE_W)) u_timer (
      .clk, .rst_n, .tick, .duty4, .rate, .com_idx, .neg, .latch_en, .latch_com);

   lcd_scan_ram #(.NUM_SEG(NUM_SEG), .DATA_W(4), .AW(AW)) u_ram (
      .clk, .rst_n, .we(ram_we), .addr(ram_addr), .wdata(ram_wdata),
      .latch_en, .latch_com, .seg_bits);

   lcd_scan_drive #(.NUM_SEG(NUM_SEG), .NUM_COM(NUM_COM), .SHARE_BASE(SHARE_BASE),
                    .GRP_W(GRP_W), .NGRP(NGRP)) u_drive (
      .clk, .rst_n, .com_idx, .neg, .duty4, .bias4, .seg_bits, .grp_rel, .com_share,
      .seg_gpio, .com_gpio, .seg_lvl, .com_lvl, .seg_rel, .com_rel);
endmodule

// File: tb/lcd_scan_tb.sv
module lcd_scan_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 0, rst_n = 0, tick = 0;
   logic        cfg_we = 0, ram_we = 0;
   logic [1:0]  cfg_addr = 0;
   logic [3:0]  cfg_wdata = 0, ram_wdata = 0;
   logic [6:0]  ram_addr = 0;
   logic [23:0] seg_gpio = 0;
   logic [3:0]  com_gpio = 0;
   logic [119:0] seg_lvl;
   logic [23:0]  com_lvl;
   logic [39:0]  seg_rel;
   logic [7:0]   com_rel;

   int checks = 0, fails = 0;

   lcd_scan u_dut (.clk, .rst_n, .tick, .cfg_we, .cfg_addr, .cfg_wdata, .ram_we,
      .ram_addr, .ram_wdata, .seg_gpio, .com_gpio, .seg_lvl, .com_lvl, .seg_rel, .com_rel);

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int sl(input int s); return int'(seg_lvl[3*s +: 3]); endfunction
   function automatic int cl(input int c); return int'(com_lvl[3*c +: 3]); endfunction

   task automatic restart();
      @(negedge clk);
      rst_n = 0; tick = 0; cfg_we = 0; ram_we = 0; seg_gpio = 0; com_gpio = 0;
      @(negedge clk); @(negedge clk);
      rst_n = 1;
      @(negedge clk);
   endtask

   task automatic run(input int n);
      tick = 1;
      repeat (n) @(negedge clk);
      tick = 0;
   endtask

   task automatic cfg(input int a, input int d);
      cfg_addr = 2'(a); cfg_wdata = 4'(d); cfg_we = 1;
      @(negedge clk);
      cfg_we = 0;
   endtask

   task automatic wr(input int a, input int d);
      ram_addr = 7'(a); ram_wdata = 4'(d); ram_we = 1;
      @(negedge clk);
      ram_we = 0;
   endtask

   task automatic t_reset();
      restart();
      chk("R1", "com0 selected", cl(0), 3);
      chk("R1", "com1 idle", cl(1), 1);
      chk("R1", "com7 idle", cl(7), 1);
      chk("R1", "seg0 dark", sl(0), 2);
      chk("R1", "seg39 dark", sl(39), 2);
      chk("R1", "seg_rel", seg_rel, 0);
      chk("R1", "com_rel", com_rel, 0);
   endtask

   task automatic t_frame();
      restart();
      run(511);
      chk("R2", "com7 at tick 511", cl(7), 3);
      chk("R3", "still positive seg0", sl(0), 2);
      run(1);
      chk("R3", "com0 negative select", cl(0), 0);
      chk("R3", "com7 negative idle", cl(7), 2);
      chk("R3", "seg0 negative dark", sl(0), 1);
   endtask

   task automatic t_map();
      restart();
      wr(11, 4'h4);
      wr(10, 4'h8);
      wr(80, 4'hF);
      run(192);
      chk("R5", "seg5 lit com3", sl(5), 0);
      chk("R5", "seg4 dark com3", sl(4), 2);
      run(192);
      chk("R5", "seg5 lit com6", sl(5), 0);
      run(64);
      chk("R5", "seg5 dark com7", sl(5), 2);
      chk("R5", "seg0 unaffected by offset 80", sl(0), 2);
   endtask

   task automatic t_latch();
      restart();
      run(70);
      wr(0, 4'h6);
      chk("R6", "mid-phase write not shown", sl(0), 2);
      run(58);
      chk("R6", "next phase shows write", sl(0), 0);
   endtask

   task automatic t_bias();
      restart();
      cfg(0, 4'h2);
      wr(14, 4'h3);
      run(64);
      chk("R4", "bias4 pos select", cl(1), 4);
      chk("R4", "bias4 pos idle", cl(0), 1);
      chk("R4", "bias4 pos lit", sl(7), 0);
      chk("R4", "bias4 pos dark", sl(6), 2);
      run(448);
      chk("R4", "bias4 neg select", cl(0), 0);
      chk("R4", "bias4 neg idle", cl(1), 3);
      chk("R4", "bias4 neg lit", sl(7), 4);
      chk("R4", "bias4 neg dark", sl(6), 2);
   endtask

   task automatic t_duty();
      restart();
      cfg(0, 4'h1);
      run(128);
      chk("R7", "com1 selected", cl(1), 3);
      chk("R7", "com4 idle", cl(4), 1);
      run(127);
      chk("R7", "com1 held long phase", cl(1), 3);
      run(1);
      chk("R7", "com2 selected", cl(2), 3);
      run(256);
      chk("R7", "wrap at 512 com0", cl(0), 0);
      chk("R7", "com4 neg idle", cl(4), 2);
      chk("R7", "com_rel off", com_rel, 0);
   endtask

   task automatic t_rate();
      restart();
      cfg(1, 6);
      run(1023);
      chk("R2", "code6 com7 at 1023", cl(7), 3);
      run(1);
      chk("R2", "code6 wrap at 1024", cl(0), 0);
      restart();
      cfg(1, 9);
      run(511);
      chk("R2", "code9 com7 at 511", cl(7), 3);
      run(1);
      chk("R2", "code9 wraps like 7", cl(0), 0);
   endtask

   task automatic t_seg_rel();
      restart();
      wr(48, 4'h2);
      wr(50, 4'h2);
      seg_gpio = 24'h000100;
      cfg(2, 4'h4);
      run(64);
      chk("R8", "seg24 gpio 1", sl(24), 1);
      chk("R8", "seg25 gpio 0 ignores data", sl(25), 0);
      chk("R10", "seg_rel group2", seg_rel, 40'h00_0F00_0000);
      chk("R8", "seg28 scanned", sl(28), 2);
      cfg(2, 0);
      chk("R8", "seg24 back to scan lit", sl(24), 0);
      seg_gpio = 24'h100100;
      cfg(3, 4'h2);
      chk("R10", "seg_rel group5", seg_rel, 40'hF0_0000_0000);
      chk("R8", "seg36 gpio 1", sl(36), 1);
   endtask

   task automatic t_com_rel();
      restart();
      com_gpio = 4'b0101;
      cfg(3, 4'h4);
      chk("R9", "no release in 8-common duty", com_rel, 0);
      chk("R9", "com5 still idle level", cl(5), 1);
      cfg(0, 4'h1);
      chk("R9", "com_rel upper", com_rel, 8'hF0);
      chk("R9", "com5 gpio 0", cl(5), 0);
      chk("R9", "com6 gpio 1", cl(6), 1);
      chk("R9", "com7 gpio 0", cl(7), 0);
   endtask

   initial begin
      t_reset();
      t_frame();
      t_map();
      t_latch();
      t_bias();
      t_duty();
      t_rate();
      t_seg_rel();
      t_com_rel();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule